// File: doc/BRIEF.md
# DAC Channel Source Selector

This block sits in one transmit channel, in front of the converter. It picks the 16-bit sample that goes to the DAC. The choices are:

- the tone generator, the DMA stream or the ADC loopback path, all passed straight through;
- an externally supplied device-specific pseudo-random word;
- two internally produced pseudo-random words, PN7 and PN15, each offered as-is or bit-inverted;
- a two-word alternating pattern;
- two ramps;
- a constant zero.

Each sample slot is marked by a one-cycle `sample_en` strobe. On that strobe the block registers one output sample. It raises `out_valid` for one cycle, and then advances its internal generators.

Two override inputs take over the programmed selection. One forces the loopback path and the other forces the device-PN path. When both are set together, both are ignored. An output stage can turn the two's complement result into offset binary by flipping the sign bit.

Top module: `dac_src_select`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `out_data` is 0x0000. The ramp counter is 0, the pattern phase is even, and both PN registers hold all ones.
- R2: The pass-through sources appear unchanged at the output: select 0 gives `tone_in`, 2 gives `dma_in`, 8 gives `loop_in` and 9 gives `devpn_in`.
- R3: Select 3, and every select from 0xC to 0xF, produce an all-zero sample.
- R4: Select 1 outputs `patt_a` on even-numbered samples and `patt_b` on odd-numbered samples. Samples are counted from 0 after reset.
- R5: The PN7 register uses the polynomial x^7+x^6+1. Each step computes feedback = s[6]^s[5] and then s <= {s[5:0], feedback}. One sample runs 16 steps, and the first feedback bit becomes word bit 15. Select 6 outputs that word and select 4 outputs its bitwise inverse.
- R6: The PN15 register uses x^15+x^14+1 with the same rule: feedback = s[14]^s[13], and 16 steps make one word with the first bit in bit 15. Select 7 outputs the word and select 5 outputs its inverse.
- R7: Select 0xA outputs the low 4 bits of the sample count, repeated in all four nibbles.
- R8: Select 0xB outputs the 16-bit sample count, which starts at 0 and increments by one on every sample.
- R9: When only `force_loopback` is set, the effective select is 8. When only `force_devpn` is set, the effective select is 9.
- R10: When both override inputs are set, the programmed `sel_code` applies.
- R11: When `offset_bin` is 1, bit 15 of the chosen sample is inverted and the other bits pass unchanged. When it is 0, the sample passes unchanged.
- R12: A strobe on `sample_en` updates `out_data` and raises `out_valid` at the next clock edge. A cycle without the strobe leaves `out_data` unchanged and `out_valid` low, and does not advance the ramp, the pattern phase or the PN registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe per output sample |
| sel_code | input | 4 | Programmed source select |
| force_loopback | input | 1 | Override to the loopback source |
| force_devpn | input | 1 | Override to the device PN source |
| offset_bin | input | 1 | 1 selects offset binary output |
| tone_in | input | 16 | Tone generator sample |
| dma_in | input | 16 | DMA data sample |
| loop_in | input | 16 | ADC loopback sample |
| devpn_in | input | 16 | Device-specific PN sample |
| patt_a | input | 16 | Pattern word for even samples |
| patt_b | input | 16 | Pattern word for odd samples |
| out_data | output | 16 | Selected, formatted sample |
| out_valid | output | 1 | High for one cycle when `out_data` is new |

## Verification
All sixteen select codes are run in both output formats, with three consecutive samples each. The pass-through inputs change on every sample, so a miswired mux leg shows up as a wrong value and not as a stale one. The repeated samples separate the two pattern words, the inverted PN words from the plain ones, and the nibble ramp from the word ramp.

All three override combinations are then applied over a set of programmed codes. This shows that a single override wins and that two overrides together fall back to `sel_code`. A gap with no strobes checks that the output holds and that the generators stay frozen: the next ramp sample must continue the count without skipping.

// File: rtl/dac_src_pkg.sv
`timescale 1ns/1ps
// Package: source codes shared by the channel source selector.
// Assumes a 4-bit select field; codes 0xC..0xF are unused.
package dac_src_pkg;
    typedef enum logic [3:0] {
        SRC_TONE      = 4'h0,
        SRC_PATTERN   = 4'h1,
        SRC_DMA       = 4'h2,
        SRC_ZERO      = 4'h3,
        SRC_PN7_INV   = 4'h4,
        SRC_PN15_INV  = 4'h5,
        SRC_PN7       = 4'h6,
        SRC_PN15      = 4'h7,
        SRC_LOOPBACK  = 4'h8,
        SRC_DEVPN     = 4'h9,
        SRC_NIB_RAMP  = 4'hA,
        SRC_WORD_RAMP = 4'hB
    } src_sel_e;
endpackage

// File: rtl/dac_lfsr_word.sv
`timescale 1ns/1ps
// Module: Fibonacci LFSR with polynomial x^ORDER + x^(ORDER-1) + 1.
// It produces WORD_W bits per advance, first bit in the MSB, and is
// seeded to all ones by reset. Assumes ORDER >= 3.
module dac_lfsr_word #(
    parameter int ORDER  = 7,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [WORD_W-1:0] word_out
);
    logic [ORDER-1:0] state_q;
    logic [ORDER-1:0] walk [0:WORD_W];
    logic [WORD_W-1:0] fb;

    assign walk[0] = state_q;

    // Unrolled walk: one feedback bit per stage
    for (genvar i = 0; i < WORD_W; i++) begin : g_step
        assign fb[i]                 = walk[i][ORDER-1] ^ walk[i][ORDER-2];
        assign walk[i+1]             = {walk[i][ORDER-2:0], fb[i]};
        assign word_out[WORD_W-1-i]  = fb[i];
    end

    // State register: seed on reset, jump a whole word per advance
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= '1;
        else if (advance) state_q <= walk[WORD_W];
    end

    // R5/R6: all-ones seed can never decay to the lock-up state
    assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
    // R12: the register only moves on an advance
    assert_lfsr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(state_q));
endmodule

// File: rtl/dac_ramp_gen.sv
`timescale 1ns/1ps
// Module: sample counter feeding the word ramp, the nibble ramp and the
// pattern phase (count LSB). Assumes WORD_W is a multiple of NIB_W.
module dac_ramp_gen #(
    parameter int WORD_W = 16,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [WORD_W-1:0] word_ramp,
    output logic [WORD_W-1:0] nib_ramp,
    output logic              odd_phase
);
    localparam int NIBS = WORD_W / NIB_W;

    logic [WORD_W-1:0] cnt_q;

    // Sample counter: clear on reset, +1 per sample
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (advance) cnt_q <= cnt_q + 1'b1;
    end

    assign word_ramp = cnt_q;
    assign odd_phase = cnt_q[0];

    // Replicate the low count nibble across the word
    for (genvar n = 0; n < NIBS; n++) begin : g_nib
        assign nib_ramp[n*NIB_W +: NIB_W] = cnt_q[NIB_W-1:0];
    end

    // R8: one increment per sample
    assert_ramp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> cnt_q == $past(cnt_q) + 1'b1);
    // R12: frozen without a sample
    assert_ramp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(cnt_q));
endmodule

// File: rtl/dac_src_select.sv
`timescale 1ns/1ps
// Module: per-channel DAC source selector. It resolves the overrides,
// multiplexes the sources, optionally converts to offset binary and
// registers one sample per sample_en strobe. The generators advance
// after each sample.
module dac_src_select #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [3:0]        sel_code,
    input  logic              force_loopback,
    input  logic              force_devpn,
    input  logic              offset_bin,
    input  logic [DATA_W-1:0] tone_in,
    input  logic [DATA_W-1:0] dma_in,
    input  logic [DATA_W-1:0] loop_in,
    input  logic [DATA_W-1:0] devpn_in,
    input  logic [DATA_W-1:0] patt_a,
    input  logic [DATA_W-1:0] patt_b,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    import dac_src_pkg::*;

    localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] pn7_w, pn15_w, ramp_w, nib_w, pick, shaped;
    logic              odd_ph;
    src_sel_e          eff_sel;

    dac_lfsr_word #(.ORDER(7), .WORD_W(DATA_W)) pn7_i (
        .clk(clk), .rst_n(rst_n), .advance(sample_en), .word_out(pn7_w));

    dac_lfsr_word #(.ORDER(15), .WORD_W(DATA_W)) pn15_i (
        .clk(clk), .rst_n(rst_n), .advance(sample_en), .word_out(pn15_w));

    dac_ramp_gen #(.WORD_W(DATA_W), .NIB_W(4)) ramp_i (
        .clk(clk), .rst_n(rst_n), .advance(sample_en),
        .word_ramp(ramp_w), .nib_ramp(nib_w), .odd_phase(odd_ph));

    // Override resolution: a single override wins, two cancel
    always_comb begin
        if (force_loopback && !force_devpn)      eff_sel = SRC_LOOPBACK;
        else if (force_devpn && !force_loopback) eff_sel = SRC_DEVPN;
        else                                     eff_sel = src_sel_e'(sel_code);
    end

    // Source multiplexer; unused codes give zero
    always_comb begin
        case (eff_sel)
            SRC_TONE:      pick = tone_in;
            SRC_PATTERN:   pick = odd_ph ? patt_b : patt_a;
            SRC_DMA:       pick = dma_in;
            SRC_ZERO:      pick = '0;
            SRC_PN7_INV:   pick = ~pn7_w;
            SRC_PN15_INV:  pick = ~pn15_w;
            SRC_PN7:       pick = pn7_w;
            SRC_PN15:      pick = pn15_w;
            SRC_LOOPBACK:  pick = loop_in;
            SRC_DEVPN:     pick = devpn_in;
            SRC_NIB_RAMP:  pick = nib_w;
            SRC_WORD_RAMP: pick = ramp_w;
            default:       pick = '0;
        endcase
    end

    // Output format: offset binary flips the sign bit
    assign shaped = offset_bin ? (pick ^ SIGN_FLIP) : pick;

    // Output register: capture one sample per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= sample_en;
            if (sample_en) out_data <= shaped;
        end
    end

    // R12: valid is the strobe delayed by one edge
    assert_valid_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> out_valid);
    assert_valid_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> !out_valid);
    // R12: data holds between samples
    assert_data_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(out_data));
    // R3, R10, R11: programmed zero with no net override yields only the sign flip
    assert_zero_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && sel_code == 4'h3 && (force_loopback == force_devpn))
        |=> out_data == ($past(offset_bin) ? SIGN_FLIP : '0));
    // R9: a lone loopback override passes loop_in
    assert_loop_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && force_loopback && !force_devpn && !offset_bin)
        |=> out_data == $past(loop_in));
endmodule

// File: tb/dac_src_select_tb.sv
`timescale 1ns/1ps
module dac_src_select_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic [3:0]  sel_code = 4'h0;
    logic        force_loopback = 1'b0, force_devpn = 1'b0, offset_bin = 1'b0;
    logic [15:0] tone_in = '0, dma_in = '0, loop_in = '0, devpn_in = '0;
    logic [15:0] patt_a = 16'h1234, patt_b = 16'hFEDC;
    logic [15:0] out_data;
    logic        out_valid;

    int checks = 0, fails = 0, k = 0;
    bit done = 0;

    logic [6:0]  m7  = '1;
    logic [14:0] m15 = '1;
    logic [15:0] mcnt = '0;

    always #5 clk = ~clk;

    dac_src_select dut_i (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sel_code(sel_code),
        .force_loopback(force_loopback), .force_devpn(force_devpn),
        .offset_bin(offset_bin), .tone_in(tone_in), .dma_in(dma_in),
        .loop_in(loop_in), .devpn_in(devpn_in), .patt_a(patt_a),
        .patt_b(patt_b), .out_data(out_data), .out_valid(out_valid));

    function automatic logic [22:0] pn7_run(input logic [6:0] s);
        logic [15:0] w; logic b;
        for (int i = 0; i < 16; i++) begin
            b = s[6] ^ s[5]; s = {s[5:0], b}; w[15-i] = b;
        end
        return {w, s};
    endfunction

    function automatic logic [30:0] pn15_run(input logic [14:0] s);
        logic [15:0] w; logic b;
        for (int i = 0; i < 16; i++) begin
            b = s[14] ^ s[13]; s = {s[13:0], b}; w[15-i] = b;
        end
        return {w, s};
    endfunction

    function automatic string tag_of(input logic [3:0] e);
        case (e)
            4'h0, 4'h2, 4'h8, 4'h9: return "R2";
            4'h1: return "R4";
            4'h4, 4'h6: return "R5";
            4'h5, 4'h7: return "R6";
            4'hA: return "R7";
            4'hB: return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One sample: drive at negedge, check at the following negedge
    task automatic step(input logic [3:0] s, input logic fl, input logic fp, input logic ob);
        logic [3:0] e; logic [15:0] w7, w15, x; logic [22:0] r7; logic [30:0] r15;
        string req;
        @(negedge clk);
        sel_code = s; force_loopback = fl; force_devpn = fp; offset_bin = ob;
        tone_in = 16'hA5A5 ^ (k * 16'h0301); dma_in = 16'h3C00 + k[15:0];
        loop_in = 16'h8001 ^ (k * 16'h1111); devpn_in = ~(k * 16'h0707);
        sample_en = 1'b1;
        e = (fl && !fp) ? 4'h8 : (fp && !fl) ? 4'h9 : s;
        r7 = pn7_run(m7); r15 = pn15_run(m15);
        w7 = r7[22:7]; w15 = r15[30:15];
        case (e)
            4'h0: x = tone_in;
            4'h1: x = mcnt[0] ? patt_b : patt_a;
            4'h2: x = dma_in;
            4'h4: x = ~w7;
            4'h5: x = ~w15;
            4'h6: x = w7;
            4'h7: x = w15;
            4'h8: x = loop_in;
            4'h9: x = devpn_in;
            4'hA: x = {4{mcnt[3:0]}};
            4'hB: x = mcnt;
            default: x = 16'h0000;
        endcase
        if (ob) x = x ^ 16'h8000;
        req = (fl ^ fp) ? "R9" : ((fl && fp) ? "R10" : tag_of(e));
        if (ob) req = {req, "/R11"};
        @(negedge clk);
        chk(req, out_data, x);
        chk("R12 valid", {15'b0, out_valid}, 16'h0001);
        m7 = r7[6:0]; m15 = r15[14:0]; mcnt = mcnt + 1'b1; k++;
        sample_en = 1'b0;
    endtask

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        chk("R1 data", out_data, 16'h0000);
        chk("R1 valid", {15'b0, out_valid}, 16'h0000);
        rst_n = 1'b1;
        // First samples after reset show the generators' start state
        step(4'hB, 0, 0, 0);
        step(4'h6, 0, 0, 0);
        // Sweep every code in both formats
        for (int s = 0; s < 16; s++)
            for (int ob = 0; ob < 2; ob++)
                for (int r = 0; r < 3; r++)
                    step(s[3:0], 1'b0, 1'b0, ob[0]);
        // Override combinations
        for (int f = 1; f < 4; f++)
            for (int s = 0; s < 16; s += 3)
                for (int ob = 0; ob < 2; ob++)
                    step(s[3:0], f[0], f[1], ob[0]);
        // Gap without strobes: hold and freeze
        held = out_data;
        for (int g = 0; g < 4; g++) begin
            @(negedge clk);
            tone_in = ~tone_in;
            chk("R12 hold", out_data, held);
            chk("R12 idle valid", {15'b0, out_valid}, 16'h0000);
        end
        step(4'hB, 0, 0, 0);
        step(4'h7, 0, 0, 0);
        step(4'h1, 0, 0, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #1_000_000;
                fails++; checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule